// File: doc/BRIEF.md
# Hierarchical Interrupt Status Controller

This block collects event pulses for one framer channel and turns them into one active-low interrupt request. Each of its status registers is eight bits wide. A bit in a status register is set on the rising edge of its event input. The request is raised only when three enable levels agree for at least one set bit:

- the matching bit in that register's source-enable mask,
- the register's bit in the block-enable register,
- the framer-enable bit of the control register.

A host reaches the block through a single-cycle synchronous read/write port. A control register chooses how status is cleared, and the choice can be changed at run time:

- **Clear-on-read:** a host read of a status register empties it.
- **Clear-by-zero-write:** a read leaves the register unchanged, and only a write of 0x00 empties it. Writing any other value does nothing.

A second control bit, when set, also wipes a register's source-enable mask as soon as its status is read. A host can use this to quiet a fault that keeps firing.

Top module: `intr_status_ctrl`

## Requirements
- R1: After reset, the control register, block-enable register, every source-enable mask and every status register read 0x00, and irqN is 1.
- R2: The control register is at 0x011A. Bit 0 is the framer enable, bit 1 is the enable auto-clear, and bit 2 is the clear mode (0 = clear-on-read, 1 = clear-by-zero-write). Bits 7..3 always read 0, and writes to them have no effect.
- R3: Status bit b of register i is set by a 0-to-1 change on evtIn[8*i+b]. It then stays set until it is cleared. An input held high does not set the bit again after a clear.
- R4: With mode 0, a read of status register i (address 0x0128+i) returns the value the register held before the access, and leaves the register at 0x00. Writes to status registers are ignored in this mode.
- R5: With mode 1, a read returns the value and leaves it unchanged. A write of 0x00 clears the register. A write of any non-zero value has no effect.
- R6: An event rising in the same cycle as a clear of its register wins: the bit is set after that cycle.
- R7: irqN is 0 exactly when all three of these hold: control bit 0 is 1; for some register i, bit i of the block-enable register (0x0118) is 1; and status i AND source-enable i (0x0120+i) is non-zero. irqN returns to 1 when the last such register is cleared.
- R8: With control bit 1 set, reading status register i clears source-enable mask i in either mode. With bit 1 clear, the masks are untouched by reads.
- R9: Status bits whose source-enable bit is 0 still latch and read back, but do not drive irqN low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current address; takes precedence over rdEn |
| rdEn | input | 1 | Read strobe for the current address |
| addr | input | ADDR_W | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle rdEn is high |
| evtIn | input | 8*NUM_REGS | Event inputs, eight per status register |
| irqN | output | 1 | Active-low interrupt request |

## Verification
rdData follows the address combinationally. The bench therefore samples it a quarter period after driving a read, which is before the edge that performs any clear. The effects of an access or an event land on the rising edge that ends that cycle:

- status set or cleared,
- enable masks updated or wiped,
- the level of irqN.

Each of these is checked at the following falling edge, either through a later read or by sampling irqN directly. The simultaneous event-and-clear cases drive both inputs in one cycle and read the result in the next cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_CTRL = 3'd1,
    RD_BLK  = 3'd2,
    RD_SRC  = 3'd3,
    RD_STAT = 3'd4
  } rdSel_e;

  // strobes passed from the address decoder to the register datapath
  typedef struct packed {
    logic       ctrlWr;
    logic       blkWr;
    logic       srcWr;
    logic       statClr;
    logic       enClr;
    rdSel_e     rdSel;
    logic [2:0] idx;
    logic [7:0] data;
  } strobe_t;

endpackage

// File: rtl/isc_decode.sv
module isc_decode
  import isc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_REGS  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h011A,
  parameter logic [ADDR_W-1:0] BLK_ADDR  = 'h0118,
  parameter logic [ADDR_W-1:0] SRC_BASE  = 'h0120,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0128
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wcMode,
  input  logic              autoClr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] REGS_A = ADDR_W'(NUM_REGS);

  logic [ADDR_W-1:0] srcOff, statOff;
  logic srcHit, statHit, rdOnly;

  assign srcOff  = addr - SRC_BASE;
  assign statOff = addr - STAT_BASE;
  assign srcHit  = srcOff < REGS_A;
  assign statHit = statOff < REGS_A;
  assign rdOnly  = rdEn & ~wrEn;

  always_comb begin
    strb         = '0;
    strb.data    = wrData;
    strb.idx     = statHit ? statOff[2:0] : srcOff[2:0];
    strb.ctrlWr  = wrEn & (addr == CTRL_ADDR);
    strb.blkWr   = wrEn & (addr == BLK_ADDR);
    strb.srcWr   = wrEn & srcHit;
    strb.statClr = statHit & (wcMode ? (wrEn & (wrData == 8'h00)) : rdOnly);
    strb.enClr   = statHit & rdOnly & autoClr;
    strb.rdSel   = RD_NONE;
    if (rdOnly) begin
      if (addr == CTRL_ADDR)     strb.rdSel = RD_CTRL;
      else if (addr == BLK_ADDR) strb.rdSel = RD_BLK;
      else if (srcHit)           strb.rdSel = RD_SRC;
      else if (statHit)          strb.rdSel = RD_STAT;
    end
  end

endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int NUM_REGS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [NUM_REGS*8-1:0] evtIn,
  output logic [7:0]            rdData,
  output logic                  irqN,
  output logic                  frmEn,
  output logic                  autoClr,
  output logic                  wcMode
);

  localparam int FLAT_W = NUM_REGS * 8;

  logic [2:0]          ctrlQ;
  logic [NUM_REGS-1:0] blkEnQ;
  logic [FLAT_W-1:0]   evtPrevQ;
  logic [FLAT_W-1:0]   srcFlat, statFlat;
  logic [NUM_REGS-1:0] regPend;
  logic [7:0]          srcSel, statSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      blkEnQ   <= '0;
      evtPrevQ <= '0;
    end else begin
      evtPrevQ <= evtIn;
      if (strb.ctrlWr) ctrlQ  <= strb.data[2:0];
      if (strb.blkWr)  blkEnQ <= strb.data[NUM_REGS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    logic [7:0] rise, srcQ, statQ;
    logic       hit;

    assign rise = evtIn[g*8 +: 8] & ~evtPrevQ[g*8 +: 8];
    assign hit  = (strb.idx == 3'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ  <= '0;
        statQ <= '0;
      end else begin
        if (strb.srcWr && hit)      srcQ <= strb.data;
        else if (strb.enClr && hit) srcQ <= 8'h00;
        statQ <= ((strb.statClr && hit) ? 8'h00 : statQ) | rise;
      end
    end

    assign srcFlat[g*8 +: 8]  = srcQ;
    assign statFlat[g*8 +: 8] = statQ;
    assign regPend[g]         = blkEnQ[g] & (|(statQ & srcQ));
  end

  always_comb begin
    srcSel  = '0;
    statSel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.idx == 3'(i)) begin
        srcSel  = srcFlat[i*8 +: 8];
        statSel = statFlat[i*8 +: 8];
      end
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_CTRL: rdData = {5'b0, ctrlQ};
      RD_BLK:  rdData = 8'(blkEnQ);
      RD_SRC:  rdData = srcSel;
      RD_STAT: rdData = statSel;
      default: rdData = 8'h00;
    endcase
  end

  assign frmEn   = ctrlQ[0];
  assign autoClr = ctrlQ[1];
  assign wcMode  = ctrlQ[2];
  assign irqN    = ~(ctrlQ[0] & (|regPend));

endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import isc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_REGS  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h011A,
  parameter logic [ADDR_W-1:0] BLK_ADDR  = 'h0118,
  parameter logic [ADDR_W-1:0] SRC_BASE  = 'h0120,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wrData,
  output logic [7:0]            rdData,
  input  logic [NUM_REGS*8-1:0] evtIn,
  output logic                  irqN
);

  strobe_t strb;
  logic    frmEn, autoClr, wcMode;

  isc_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR),
    .BLK_ADDR(BLK_ADDR), .SRC_BASE(SRC_BASE), .STAT_BASE(STAT_BASE)
  ) decode_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .wcMode(wcMode), .autoClr(autoClr), .strb(strb)
  );

  isc_datapath #(.NUM_REGS(NUM_REGS)) datapath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn),
    .rdData(rdData), .irqN(irqN), .frmEn(frmEn),
    .autoClr(autoClr), .wcMode(wcMode)
  );

endmodule

// File: rtl/intr_status_ctrl_chk.sv
module intr_status_ctrl_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_REGS  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h011A,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0128
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [7:0]            rdData,
  input logic [NUM_REGS*8-1:0] evtIn,
  input logic                  irqN,
  input logic                  frmEn,
  input logic                  autoClr,
  input logic                  wcMode
);

  // framer-level enable off keeps the request inactive
  assert_frm_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !frmEn |-> irqN);

  assert_ctrl_resv_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == CTRL_ADDR) |-> rdData[7:3] == 5'b0);

  // a clear-on-read of register 0 with no new event leaves it empty
  assert_rur_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == STAT_BASE && !wcMode && evtIn[7:0] == 8'h00)
    |=> ((rdEn && !wrEn && addr == STAT_BASE) |-> rdData == 8'h00));

  // in zero-write mode without auto-clear only a write can release the request
  assert_wc_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wcMode && !autoClr && !irqN && !wrEn) |=> !irqN);

  // the request only asserts after an event or a register write
  assert_fall_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> ($past(wrEn) || $past(|evtIn)));

endmodule

bind intr_status_ctrl intr_status_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
  .CTRL_ADDR(CTRL_ADDR), .STAT_BASE(STAT_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .evtIn(evtIn), .irqN(irqN), .frmEn(frmEn),
  .autoClr(autoClr), .wcMode(wcMode)
);

// File: tb/intr_status_ctrl_tb_top.sv
module intr_status_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CTRL  = 16'h011A;
  localparam logic [15:0] A_BLK   = 16'h0118;
  localparam logic [15:0] A_SRC0  = 16'h0120;
  localparam logic [15:0] A_SRC1  = 16'h0121;
  localparam logic [15:0] A_STAT0 = 16'h0128;
  localparam logic [15:0] A_STAT1 = 16'h0129;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [15:0] evtIn = '0;
  logic        irqN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_status_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .irqN(irqN)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    checks++;
    if (irqN !== exp) begin
      fails++;
      $display("FAIL %s: irqN actual %b expected %b", tag, irqN, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #(CLK_PERIOD/4);
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk8(tag, d, exp);
  endtask

  task automatic pulse(input int r, input logic [7:0] p);
    evtIn[r*8 +: 8] = p;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chkIrq("R1 reset irq", 1'b1);
    rdChk("R1 reset ctrl", A_CTRL, 8'h00);
    rdChk("R1 reset blk", A_BLK, 8'h00);
    rdChk("R1 reset src0", A_SRC0, 8'h00);
    rdChk("R1 reset src1", A_SRC1, 8'h00);
    rdChk("R1 reset stat0", A_STAT0, 8'h00);
    rdChk("R1 reset stat1", A_STAT1, 8'h00);

    // R2 every control value, reserved bits masked
    for (int v = 0; v < 256; v++) begin
      wr(A_CTRL, 8'(v));
      rdChk("R2 ctrl readback", A_CTRL, 8'(v) & 8'h07);
    end

    // R3 R4 R9 single-bit sweep, source masks zero, clear-on-read
    wr(A_CTRL, 8'h01);
    wr(A_BLK, 8'h03);
    wr(A_SRC0, 8'h00);
    wr(A_SRC1, 8'h00);
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 8; b++) begin
        pulse(r, 8'(1 << b));
        chkIrq("R9 masked bit no irq", 1'b1);
        rdChk("R9 masked bit latched", r ? A_STAT1 : A_STAT0, 8'(1 << b));
        rdChk("R4 cleared after read", r ? A_STAT1 : A_STAT0, 8'h00);
        // held level sets once only
        evtIn[r*8 + b] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rdChk("R3 held level sets", r ? A_STAT1 : A_STAT0, 8'(1 << b));
        rdChk("R3 held level no reset", r ? A_STAT1 : A_STAT0, 8'h00);
        evtIn = '0;
        @(negedge clk);
      end
    end

    // R4 writes ignored in clear-on-read mode
    pulse(0, 8'h3C);
    wr(A_STAT0, 8'hFF);
    wr(A_STAT0, 8'h00);
    rdChk("R4 write ignored", A_STAT0, 8'h3C);
    pulse(0, 8'hA5);
    pulse(1, 8'h5A);
    rdChk("R4 pattern reg0", A_STAT0, 8'hA5);
    rdChk("R4 pattern reg1", A_STAT1, 8'h5A);

    // R5 clear-by-zero-write
    wr(A_CTRL, 8'h04);
    pulse(1, 8'h81);
    rdChk("R5 read keeps 1", A_STAT1, 8'h81);
    rdChk("R5 read keeps 2", A_STAT1, 8'h81);
    wr(A_STAT1, 8'h7E);
    rdChk("R5 nonzero write ignored", A_STAT1, 8'h81);
    wr(A_STAT1, 8'h00);
    rdChk("R5 zero write clears", A_STAT1, 8'h00);

    // R6 event beats clear, zero-write mode
    pulse(0, 8'h01);
    wrEn = 1'b1; addr = A_STAT0; wrData = 8'h00; evtIn[3] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
    rdChk("R6 event wins zero write", A_STAT0, 8'h08);
    wr(A_STAT0, 8'h00);

    // R6 event beats clear, clear-on-read mode
    wr(A_CTRL, 8'h00);
    pulse(0, 8'h01);
    rdEn = 1'b1; addr = A_STAT0; evtIn[2] = 1'b1;
    #(CLK_PERIOD/4);
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0; evtIn = '0;
    chk8("R6 read returns old", d, 8'h01);
    rdChk("R6 event wins read clear", A_STAT0, 8'h04);

    // R7 enable-level sweep, status fixed in zero-write mode
    wr(A_CTRL, 8'h04);
    wr(A_STAT1, 8'h00);
    pulse(0, 8'h01);
    pulse(1, 8'h10);
    for (int fe = 0; fe < 2; fe++) begin
      for (int bk = 0; bk < 4; bk++) begin
        for (int sm = 0; sm < 4; sm++) begin
          wr(A_CTRL, 8'(4 | fe));
          wr(A_BLK, 8'(bk));
          wr(A_SRC0, sm[0] ? 8'h01 : 8'hFE);
          wr(A_SRC1, sm[1] ? 8'h10 : 8'hEF);
          chkIrq("R7 enable combination",
                 !(fe[0] && ((bk[0] && sm[0]) || (bk[1] && sm[1]))));
        end
      end
    end

    // R7 release on zero write
    wr(A_CTRL, 8'h05);
    wr(A_BLK, 8'h03);
    wr(A_SRC0, 8'hFF);
    wr(A_SRC1, 8'h00);
    chkIrq("R7 pending", 1'b0);
    rdChk("R5 read stat0", A_STAT0, 8'h01);
    chkIrq("R5 read keeps irq", 1'b0);
    wr(A_STAT0, 8'h00);
    chkIrq("R7 release on zero write", 1'b1);

    // R7 release on read
    wr(A_CTRL, 8'h01);
    pulse(0, 8'h02);
    chkIrq("R7 event raises irq", 1'b0);
    rdChk("R4 read stat0 rur", A_STAT0, 8'h02);
    chkIrq("R7 release on read", 1'b1);

    // R8 auto-clear of source masks
    wr(A_CTRL, 8'h03);
    wr(A_SRC0, 8'hFF);
    wr(A_SRC1, 8'h55);
    pulse(0, 8'h01);
    rdChk("R8 read stat0", A_STAT0, 8'h01);
    rdChk("R8 src0 wiped", A_SRC0, 8'h00);
    rdChk("R8 src1 untouched", A_SRC1, 8'h55);
    wr(A_CTRL, 8'h01);
    wr(A_SRC0, 8'hFF);
    rdChk("R8 read stat0 no autoclr", A_STAT0, 8'h00);
    rdChk("R8 src0 kept", A_SRC0, 8'hFF);
    wr(A_CTRL, 8'h06);
    rdChk("R8 wc read stat1", A_STAT1, 8'h10);
    rdChk("R8 wc src1 wiped", A_SRC1, 8'h00);
    rdChk("R8 wc stat1 kept", A_STAT1, 8'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule